// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is a purely combinational arithmetic logic unit assembled from identical one-bit slices. Each slice takes one bit of each operand. It can complement either bit on its way in. It then forms the AND, the OR, the XOR and the full-adder sum of the two conditioned bits, and a four-way selector picks one of these as its output bit. Slice carries ripple from the least significant bit upward. The carry into the bottom slice is an input of the block.

Two settings give subtraction: the B complement control at 1 and the incoming carry at 1, with the add function selected. The datapath then forms A + ~B + 1. The block also reports a zero flag, the carry out of the top slice, and a signed-overflow flag taken from the carries around the top slice. The slice count is a parameter with a default of four. All outputs are plain combinational functions of the present inputs.

Top module: `sliced_alu`

## Requirements
- R1: With `op_sel` = 2'b00 the result is the bitwise AND of the conditioned operands, where the conditioned A is `~opnd_a` when `inv_a` = 1 and `opnd_a` otherwise, and the conditioned B is formed likewise from `inv_b`.
- R2: With `op_sel` = 2'b01 the result is the bitwise OR of the conditioned operands.
- R3: With `op_sel` = 2'b10 the result is the bitwise XOR of the conditioned operands.
- R4: With `op_sel` = 2'b11 the result is the low W bits of conditioned A + conditioned B + `carry_in`.
- R5: For every value of `op_sel`, `carry_out` equals bit W of conditioned A + conditioned B + `carry_in`, so it is never unknown.
- R6: With `op_sel` = 2'b11, `inv_a` = 0, `inv_b` = 1 and `carry_in` = 1, the result is A − B modulo 2^W, and `carry_out` is 1 exactly when A ≥ B as unsigned numbers.
- R7: `zero` is 1 exactly when every bit of `result` is 0.
- R8: `overflow` is 1 exactly when the conditioned operands have equal top bits and the top bit of their W-bit sum with carry differs from them, i.e. the carry into the top slice differs from the carry out of it. The flag is driven for every `op_sel` and carries meaning only for the add function.
- R9: With `op_sel` = 2'b10, `inv_a` = 0 and `inv_b` = 1, the result is all ones exactly when A equals B. With the R6 subtract setting, `zero` is 1 exactly when A equals B.
- R10: All outputs depend on the present inputs only. A change of any input shows at the outputs in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| inv_a | input | 1 | Complement operand A before every function |
| inv_b | input | 1 | Complement operand B before every function |
| carry_in | input | 1 | Carry into the least significant slice (1 for subtract) |
| op_sel | input | 2 | Function select: 00 AND, 01 OR, 10 XOR, 11 add |
| result | output | W | Selected function output |
| carry_out | output | 1 | Carry out of the most significant slice |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the add path |

## Verification
No output has a register on its path, so every result, carry and flag is due in the same time step as the input change that causes it, zero cycles after the stimulus. The bench applies each input combination on a rising clock edge and reads the outputs on the following falling edge. By then the ripple chain has settled, and the sample never meets a later change of the inputs. The sweep covers every operand pair, both complement controls, both carry values and all four functions. For each combination the bench computes the expected sum, carry and overflow arithmetically.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_ADD = 2'b11
    } alu_op_e;

    // Conditioned operand bits entering the function blocks of a slice
    typedef struct packed {
        logic a;
        logic b;
    } slice_in_t;

    // Candidate outputs of one slice, one per function
    typedef struct packed {
        logic f_and;
        logic f_or;
        logic f_xor;
        logic f_sum;
    } slice_fn_t;

    function automatic logic cond_bit(input logic bit_in, input logic flip);
        return bit_in ^ flip;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    inv_a,
    input  logic    inv_b,
    input  logic    c_in,
    input  alu_op_e op,
    output logic    y,
    output logic    c_out
);
    slice_in_t cin_s;
    slice_fn_t fn;

    always_comb begin
        cin_s.a = cond_bit(a_bit, inv_a);
        cin_s.b = cond_bit(b_bit, inv_b);
    end

    always_comb begin
        fn.f_and = cin_s.a & cin_s.b;
        fn.f_or  = cin_s.a | cin_s.b;
        fn.f_xor = cin_s.a ^ cin_s.b;
        fn.f_sum = fn.f_xor ^ c_in;
    end

    assign c_out = maj3(cin_s.a, cin_s.b, c_in);

    // Four-way selector over the function outputs
    always_comb begin
        y = fn.f_and;
        case (op)
            OP_AND: y = fn.f_and;
            OP_OR:  y = fn.f_or;
            OP_XOR: y = fn.f_xor;
            OP_ADD: y = fn.f_sum;
            default: y = fn.f_and;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int W = 4
) (
    input  logic [W-1:0] res,
    input  logic         c_into_top,
    input  logic         c_out_top,
    output logic         zero,
    output logic         overflow
);
    assign zero     = ~|res;
    assign overflow = c_into_top ^ c_out_top;
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         inv_a,
    input  logic         inv_b,
    input  logic         carry_in,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         zero,
    output logic         overflow
);
    localparam int TOP = W - 1;

    alu_op_e       op;
    logic [W:0]    chain;

    assign op       = alu_op_e'(op_sel);
    assign chain[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_slice u_slice (
            .a_bit (opnd_a[i]),
            .b_bit (opnd_b[i]),
            .inv_a (inv_a),
            .inv_b (inv_b),
            .c_in  (chain[i]),
            .op    (op),
            .y     (result[i]),
            .c_out (chain[i+1])
        );
    end

    assign carry_out = chain[W];

    alu_flags #(.W(W)) u_flags (
        .res        (result),
        .c_into_top (chain[TOP]),
        .c_out_top  (chain[W]),
        .zero       (zero),
        .overflow   (overflow)
    );
endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         inv_a,
    input logic         inv_b,
    input logic         carry_in,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         zero,
    input logic         overflow
);
    logic [W-1:0] ca, cb;
    logic [W:0]   wide;
    logic         known;

    always_comb begin
        ca    = inv_a ? ~opnd_a : opnd_a;
        cb    = inv_b ? ~opnd_b : opnd_b;
        wide  = {1'b0, ca} + {1'b0, cb} + {{W{1'b0}}, carry_in};
        known = !$isunknown({opnd_a, opnd_b, inv_a, inv_b, carry_in, op_sel});
    end

    always_comb begin
        if (known) begin
            // R4
            add_sum_chk: assert (op_sel != 2'b11 || result == wide[W-1:0]);
            // R5
            carry_any_op_chk: assert (carry_out == wide[W]);
            // R3
            xor_form_chk: assert (op_sel != 2'b10 || result == ((ca | cb) & ~(ca & cb)));
            // R8
            signed_ovf_chk: assert (overflow == ((ca[W-1] == cb[W-1]) && (wide[W-1] != ca[W-1])));
            // R9
            sub_equal_chk: assert (!(op_sel == 2'b11 && !inv_a && inv_b && carry_in)
                                   || zero == (opnd_a == opnd_b));
            // R7
            zero_flag_chk: assert (zero == (result == '0));
        end
    end
endmodule

bind sliced_alu sliced_alu_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero),
    .overflow  (overflow)
);

// File: tb/sliced_alu_bench.sv
`timescale 1ns/1ps
module sliced_alu_bench;
    localparam int W    = 4;
    localparam int N    = 1 << W;
    localparam int MASK = N - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] opnd_a, opnd_b, result;
    logic         inv_a, inv_b, carry_in, carry_out, zero, overflow;
    logic [1:0]   op_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    sliced_alu #(.W(W)) u_sliced_alu (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .inv_a     (inv_a),
        .inv_b     (inv_b),
        .carry_in  (carry_in),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out),
        .zero      (zero),
        .overflow  (overflow)
    );

    task automatic check(input string tag, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (op=%0d ia=%0d ib=%0d ci=%0d a=%0d b=%0d)",
                     tag, actual, expected, op_sel, inv_a, inv_b, carry_in, opnd_a, opnd_b);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        opnd_a = '0; opnd_b = '0; inv_a = 1'b0; inv_b = 1'b0;
        carry_in = 1'b0; op_sel = 2'b00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state with all inputs low
        check("R1 idle result", int'(result), 0);
        check("R7 idle zero", int'(zero), 1);
        check("R5 idle carry", int'(carry_out), 0);

        // R10: change without any clock edge, observe after a short delay
        opnd_a = 4'd5; opnd_b = 4'd3; op_sel = 2'b11;
        #0.5;
        check("R10 same-step add", int'(result), 8);
        check("R10 same-step ovf", int'(overflow), 1);

        for (int op = 0; op < 4; op++) begin
            for (int ia = 0; ia < 2; ia++) begin
                for (int ib = 0; ib < 2; ib++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        for (int a = 0; a < N; a++) begin
                            for (int b = 0; b < N; b++) begin
                                int ea, eb, sum, exp_res, exp_ovf;
                                @(posedge clk);
                                opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
                                inv_a = ia[0]; inv_b = ib[0]; carry_in = ci[0];
                                op_sel = op[1:0];
                                @(negedge clk);
                                ea  = ia ? (~a & MASK) : a;
                                eb  = ib ? (~b & MASK) : b;
                                sum = ea + eb + ci;
                                case (op)
                                    0: exp_res = ea & eb;
                                    1: exp_res = ea | eb;
                                    2: exp_res = ea ^ eb;
                                    default: exp_res = sum & MASK;
                                endcase
                                case (op)
                                    0: check("R1 and", int'(result), exp_res);
                                    1: check("R2 or", int'(result), exp_res);
                                    2: check("R3 xor", int'(result), exp_res);
                                    default: check("R4 add", int'(result), exp_res);
                                endcase
                                check("R5 carry", int'(carry_out), (sum >> W) & 1);
                                check("R7 zero", int'(zero), (exp_res == 0) ? 1 : 0);
                                exp_ovf = (((ea >> (W-1)) & 1) == ((eb >> (W-1)) & 1)) &&
                                          (((sum >> (W-1)) & 1) != ((ea >> (W-1)) & 1)) ? 1 : 0;
                                check("R8 overflow", int'(overflow), exp_ovf);
                                if (op == 3 && ia == 0 && ib == 1 && ci == 1) begin
                                    check("R6 difference", int'(result), (a - b) & MASK);
                                    check("R6 borrow", int'(carry_out), (a >= b) ? 1 : 0);
                                    check("R9 sub equal", int'(zero), (a == b) ? 1 : 0);
                                end
                                if (op == 2 && ia == 0 && ib == 1) begin
                                    check("R9 xor equal", (int'(result) == MASK) ? 1 : 0,
                                          (a == b) ? 1 : 0);
                                end
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule